// File: doc/BRIEF.md
# Stream Buffer Sequential Prefetcher

This block sits beside a cache and watches each lookup together with the cache's hit flag. It keeps a small pool of circular stream buffers. Each buffer holds the addresses of lines fetched ahead of an earlier miss, plus a valid bit and a pending bit for each entry. On a cache miss only the oldest entry (the head) of each buffer is compared. A ready head hands its line to the cache and the buffer moves on. A head whose fill has not yet returned stalls the lookup. A miss that matches no head takes over the least recently used buffer and fills it with the lines that follow the miss.

Each buffer keeps its own signed stride, taken from the lookup port when the buffer is allocated, so it can follow streams that do not use a unit step. Prefetch requests go to memory one per cycle at most. Fill responses name the buffer, the entry and the line address, so they may return in any order. All addresses are line addresses and wrap modulo 2^AW. NBUF and DEPTH must be powers of two, each at least 2.

Top module: `sbp_prefetcher`

## Requirements
- R1: A lookup with the cache hit flag set causes no supply, no stall and no allocation, so the prefetch request stream does not change.
- R2: A missing lookup whose address equals a valid, non-pending buffer head raises sup_valid in the same cycle. sup_buf and sup_slot name that head, and the lowest-numbered matching buffer wins.
- R3: A missing lookup whose address equals a valid head that is still pending raises lk_stall in the same cycle. It produces no supply and no allocation.
- R4: A missing lookup that matches no valid head allocates the victim buffer and discards all of its entries. Its entries 0 to DEPTH-1 get addresses miss+k*stride for k = 1 to DEPTH, each valid, pending and not yet requested, and the head returns to entry 0.
- R5: At most one prefetch request is issued per cycle. It goes to the unrequested valid entry with the lowest flat index buf*DEPTH+slot, and it carries that entry's buffer, slot and address.
- R6: When a head is supplied, its slot is reloaded with the buffer's last address plus its stride. That slot becomes the new tail and is marked unrequested, so a request follows in the next cycle.
- R7: A fill marks an entry ready only if the entry is valid, requested and pending, and its stored address equals fill_addr. Any other fill is ignored.
- R8: Buffers are replaced in least recently used order. Allocation and supply each count as a use, and after reset buffer 0 is the first victim, then 1, 2 and so on.
- R9: The stride is a signed two's complement value, and every computed address wraps modulo 2^AW.
- R10: After reset all entries are invalid, and no request, supply or stall is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_addr | input | AW | Line address looked up |
| lk_cache_hit | input | 1 | The cache already holds the line |
| lk_stride | input | SW | Signed stride recorded on allocation |
| lk_stall | output | 1 | Head matched but its line is still in flight |
| sup_valid | output | 1 | A buffer head supplies the line to the cache |
| sup_buf | output | log2(NBUF) | Supplying buffer |
| sup_slot | output | log2(DEPTH) | Supplying entry |
| pf_req_valid | output | 1 | Prefetch request to memory |
| pf_req_addr | output | AW | Requested line address |
| pf_req_buf | output | log2(NBUF) | Buffer that owns the request |
| pf_req_slot | output | log2(DEPTH) | Entry that owns the request |
| fill_valid | input | 1 | Memory returns a line |
| fill_addr | input | AW | Address of the returned line |
| fill_buf | input | log2(NBUF) | Buffer named by the response |
| fill_slot | input | log2(DEPTH) | Entry named by the response |

## Verification
A wrong entry address shows up on pf_req_addr in the cycle that entry is requested. An allocation or reload error is therefore visible one cycle after the lookup that caused it. A wrong valid or pending bit shows up the next time a lookup reaches that head: the design supplies where it should stall, or allocates where it should match. A wrong replacement order shows up as a request for the wrong buffer index right after the next full miss. The reference model is compared against every output on every cycle, with out-of-order and unmatched fills mixed in, so each of these faults is caught within a few cycles of the first port activity it affects.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // State bits kept for each stream buffer entry
  typedef struct packed {
    logic valid;    // entry holds an address
    logic pending;  // line not yet returned from memory
    logic issued;   // request already sent to memory
  } sbp_flags_t;
endpackage

// File: rtl/sbp_lru.sv
module sbp_lru #(
  parameter int NBUF = 4,
  localparam int BW = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [BW-1:0] touch_idx,
  output logic [BW-1:0] victim
);
  logic [NBUF-1:0][BW-1:0] age_q, age_d;

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int b = 0; b < NBUF; b++)
        if (age_q[b] < age_q[touch_idx]) age_d[b] = age_q[b] + 1'b1;
      age_d[touch_idx] = '0;
    end
  end

  always_comb begin
    victim = '0;
    for (int b = 0; b < NBUF; b++)
      if (age_q[b] == BW'(NBUF - 1)) victim = BW'(b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBUF; b++) age_q[b] <= BW'(NBUF - 1 - b);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end
endmodule

// File: rtl/sbp_pick.sv
module sbp_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = |req;
    gnt_idx   = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) gnt_idx = IW'(i);
  end
endmodule

// File: rtl/sbp_buffer.sv
module sbp_buffer #(
  parameter int AW    = 16,
  parameter int SW    = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_en,
  input  logic [AW-1:0]               alloc_addr,
  input  logic signed [SW-1:0]        alloc_stride,
  input  logic                        adv_en,
  input  logic                        fill_en,
  input  logic [PW-1:0]               fill_slot,
  input  logic [AW-1:0]               fill_addr,
  input  logic                        iss_en,
  input  logic [PW-1:0]               iss_slot,
  output logic [PW-1:0]               head,
  output logic [DEPTH-1:0][AW-1:0]    tags,
  output sbp_pkg::sbp_flags_t [DEPTH-1:0] flags
);
  import sbp_pkg::*;

  logic [DEPTH-1:0][AW-1:0] tag_q, tag_d;
  sbp_flags_t [DEPTH-1:0]   flg_q, flg_d;
  logic [PW-1:0]            head_q, head_d;
  logic [AW-1:0]            last_q, last_d;
  logic signed [SW-1:0]     stride_q, stride_d;
  logic [AW-1:0]            step_cur, step_new, acc;
  logic                     upd;

  assign step_cur = {{(AW-SW){stride_q[SW-1]}}, stride_q};
  assign step_new = {{(AW-SW){alloc_stride[SW-1]}}, alloc_stride};
  assign upd      = alloc_en | adv_en | fill_en | iss_en;

  always_comb begin
    tag_d = tag_q; flg_d = flg_q; head_d = head_q;
    last_d = last_q; stride_d = stride_q; acc = '0;
    if (iss_en) flg_d[iss_slot].issued = 1'b1;
    if (fill_en && flg_q[fill_slot].valid && flg_q[fill_slot].issued &&
        flg_q[fill_slot].pending && tag_q[fill_slot] == fill_addr)
      flg_d[fill_slot].pending = 1'b0;
    if (adv_en) begin
      tag_d[head_q] = last_q + step_cur;
      flg_d[head_q] = '{valid: 1'b1, pending: 1'b1, issued: 1'b0};
      last_d        = last_q + step_cur;
      head_d        = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    end
    if (alloc_en) begin
      acc = alloc_addr;
      for (int i = 0; i < DEPTH; i++) begin
        acc      = acc + step_new;
        tag_d[i] = acc;
        flg_d[i] = '{valid: 1'b1, pending: 1'b1, issued: 1'b0};
      end
      last_d   = acc;
      head_d   = '0;
      stride_d = alloc_stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0; flg_q <= '0; head_q <= '0; last_q <= '0; stride_q <= '0;
    end else if (upd) begin
      tag_q <= tag_d; flg_q <= flg_d; head_q <= head_d;
      last_q <= last_d; stride_q <= stride_d;
    end
  end

  assign head  = head_q;
  assign tags  = tag_q;
  assign flags = flg_q;
endmodule

// File: rtl/sbp_prefetcher.sv
module sbp_prefetcher #(
  parameter int AW    = 16,
  parameter int SW    = 8,
  parameter int NBUF  = 4,
  parameter int DEPTH = 4,
  localparam int BW   = $clog2(NBUF),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [AW-1:0]        lk_addr,
  input  logic                 lk_cache_hit,
  input  logic signed [SW-1:0] lk_stride,
  output logic                 lk_stall,
  output logic                 sup_valid,
  output logic [BW-1:0]        sup_buf,
  output logic [PW-1:0]        sup_slot,
  output logic                 pf_req_valid,
  output logic [AW-1:0]        pf_req_addr,
  output logic [BW-1:0]        pf_req_buf,
  output logic [PW-1:0]        pf_req_slot,
  input  logic                 fill_valid,
  input  logic [AW-1:0]        fill_addr,
  input  logic [BW-1:0]        fill_buf,
  input  logic [PW-1:0]        fill_slot
);
  import sbp_pkg::*;
  localparam int NE = NBUF * DEPTH;
  localparam int IW = $clog2(NE);

  logic [NBUF-1:0][DEPTH-1:0][AW-1:0] tags_all;
  sbp_flags_t [NBUF-1:0][DEPTH-1:0]   flags_all;
  logic [NBUF-1:0][PW-1:0]            head_all;
  logic [NBUF-1:0]                    head_hit, head_pend;
  logic [NE-1:0]                      need;
  logic [BW-1:0]                      sel, victim, touch_idx;
  logic                               any_hit, miss, alloc, gnt_valid;
  logic [IW-1:0]                      gnt_idx;

  // Head compare per buffer and list of entries awaiting a request
  always_comb begin
    for (int b = 0; b < NBUF; b++) begin
      head_hit[b]  = flags_all[b][head_all[b]].valid &&
                     tags_all[b][head_all[b]] == lk_addr;
      head_pend[b] = flags_all[b][head_all[b]].pending;
      for (int s = 0; s < DEPTH; s++)
        need[b*DEPTH+s] = flags_all[b][s].valid & ~flags_all[b][s].issued;
    end
    sel = '0;
    for (int b = NBUF - 1; b >= 0; b--)
      if (head_hit[b]) sel = BW'(b);
  end

  assign any_hit   = |head_hit;
  assign miss      = lk_valid & ~lk_cache_hit;
  assign sup_valid = miss & any_hit & ~head_pend[sel];
  assign lk_stall  = miss & any_hit & head_pend[sel];
  assign alloc     = miss & ~any_hit;
  assign sup_buf   = sel;
  assign sup_slot  = head_all[sel];
  assign touch_idx = sup_valid ? sel : victim;

  sbp_lru #(.NBUF(NBUF)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(sup_valid | alloc),
    .touch_idx(touch_idx), .victim(victim)
  );

  sbp_pick #(.N(NE)) u_pick (.req(need), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx));

  assign pf_req_valid = gnt_valid;
  assign pf_req_buf   = gnt_idx[IW-1:PW];
  assign pf_req_slot  = gnt_idx[PW-1:0];
  assign pf_req_addr  = tags_all[pf_req_buf][pf_req_slot];

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    sbp_buffer #(.AW(AW), .SW(SW), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc && victim == BW'(b)),
      .alloc_addr(lk_addr), .alloc_stride(lk_stride),
      .adv_en(sup_valid && sel == BW'(b)),
      .fill_en(fill_valid && fill_buf == BW'(b)),
      .fill_slot(fill_slot), .fill_addr(fill_addr),
      .iss_en(gnt_valid && pf_req_buf == BW'(b)),
      .iss_slot(pf_req_slot),
      .head(head_all[b]), .tags(tags_all[b]), .flags(flags_all[b])
    );
  end
endmodule

// File: rtl/sbp_prefetcher_chk.sv
module sbp_prefetcher_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_cache_hit,
  input logic lk_stall,
  input logic sup_valid,
  input logic pf_req_valid
);
  // R1: a cache hit never produces a supply or a stall
  assert_hit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_cache_hit) |-> (!sup_valid && !lk_stall));

  // R2: supply only answers a lookup that missed in the cache
  assert_sup_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sup_valid |-> (lk_valid && !lk_cache_hit));

  // R3: stall and supply never occur together
  assert_stall_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sup_valid && lk_stall));

  // R4: a full miss leaves unrequested entries, so a request follows
  assert_alloc_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_cache_hit && !sup_valid && !lk_stall) |=> pf_req_valid);

  // R6: a supplied head reloads its slot and requests it next cycle
  assert_reload_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sup_valid |=> pf_req_valid);
endmodule

bind sbp_prefetcher sbp_prefetcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_cache_hit(lk_cache_hit),
  .lk_stall(lk_stall), .sup_valid(sup_valid), .pf_req_valid(pf_req_valid)
);

// File: tb/sbp_prefetcher_bench.sv
module sbp_prefetcher_bench;
  localparam int NB = 4, ND = 4;
  localparam int MASK = 32'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_cache_hit = 1'b0, fill_valid = 1'b0;
  logic [15:0] lk_addr = '0, fill_addr = '0;
  logic signed [7:0] lk_stride = '0;
  logic [1:0] fill_buf = '0, fill_slot = '0;
  logic lk_stall, sup_valid, pf_req_valid;
  logic [1:0] sup_buf, sup_slot, pf_req_buf, pf_req_slot;
  logic [15:0] pf_req_addr;

  always #10 clk = ~clk;

  sbp_prefetcher u_sbp_prefetcher (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_cache_hit(lk_cache_hit), .lk_stride(lk_stride), .lk_stall(lk_stall),
    .sup_valid(sup_valid), .sup_buf(sup_buf), .sup_slot(sup_slot),
    .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr),
    .pf_req_buf(pf_req_buf), .pf_req_slot(pf_req_slot),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_buf(fill_buf), .fill_slot(fill_slot)
  );

  // Behavioural reference state
  int m_tag[NB][ND];
  bit m_val[NB][ND], m_pend[NB][ND], m_iss[NB][ND];
  int m_head[NB], m_last[NB], m_str[NB], m_age[NB];
  // Memory model: outstanding requests
  int q_buf[$], q_slot[$], q_addr[$];
  bit mem_on = 0;
  bit inj_v = 0; int inj_b, inj_s, inj_a;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  function automatic void touch(input int b);
    for (int i = 0; i < NB; i++) if (m_age[i] < m_age[b]) m_age[i]++;
    m_age[b] = 0;
  endfunction

  task automatic step(input bit v, input bit hit, input int addr, input int stride);
    bit fv = 0; int fb = 0, fs = 0, fa = 0;
    bit e_sup = 0, e_stall = 0, e_alloc = 0, e_req = 0, f_ok = 0;
    int mb = -1, rb = 0, rs = 0, vb = 0;
    @(negedge clk);
    if (inj_v) begin
      fv = 1; fb = inj_b; fs = inj_s; fa = inj_a; inj_v = 0;
    end else if (mem_on && q_addr.size() > 0 && ($urandom % 3) != 0) begin
      int k = int'($urandom % q_addr.size());
      fv = 1; fb = q_buf[k]; fs = q_slot[k]; fa = q_addr[k];
      q_buf.delete(k); q_slot.delete(k); q_addr.delete(k);
    end
    lk_valid = v; lk_cache_hit = hit; lk_addr = 16'(addr); lk_stride = 8'(stride);
    fill_valid = fv; fill_buf = 2'(fb); fill_slot = 2'(fs); fill_addr = 16'(fa);
    #5;
    // expected outputs from model state
    if (v && !hit) begin
      for (int b = NB - 1; b >= 0; b--)
        if (m_val[b][m_head[b]] && m_tag[b][m_head[b]] == (addr & MASK)) mb = b;
      if (mb >= 0) begin
        if (m_pend[mb][m_head[mb]]) e_stall = 1; else e_sup = 1;
      end else e_alloc = 1;
    end
    for (int i = NB * ND - 1; i >= 0; i--)
      if (m_val[i / ND][i % ND] && !m_iss[i / ND][i % ND]) begin
        e_req = 1; rb = i / ND; rs = i % ND;
      end
    chk(lk_stall == e_stall, "lk_stall", lk_stall, e_stall);
    chk(sup_valid == e_sup, "sup_valid", sup_valid, e_sup);
    if (e_sup) begin
      chk(sup_buf == 2'(mb) && sup_slot == 2'(m_head[mb]), "sup_buf/slot",
          {sup_buf, sup_slot}, mb * 4 + m_head[mb]);
    end
    chk(pf_req_valid == e_req, "pf_req_valid", pf_req_valid, e_req);
    if (e_req) begin
      chk(pf_req_buf == 2'(rb) && pf_req_slot == 2'(rs), "pf_req_buf/slot",
          {pf_req_buf, pf_req_slot}, rb * 4 + rs);
      chk(int'(pf_req_addr) == m_tag[rb][rs], "pf_req_addr", pf_req_addr, m_tag[rb][rs]);
    end
    // model update, fill acceptance judged on state before this edge
    if (fv) f_ok = m_val[fb][fs] && m_iss[fb][fs] && m_pend[fb][fs] && m_tag[fb][fs] == fa;
    if (e_req) begin
      m_iss[rb][rs] = 1;
      q_buf.push_back(rb); q_slot.push_back(rs); q_addr.push_back(m_tag[rb][rs]);
    end
    if (f_ok) m_pend[fb][fs] = 0;
    if (e_sup) begin
      int h = m_head[mb];
      m_last[mb] = (m_last[mb] + m_str[mb]) & MASK;
      m_tag[mb][h] = m_last[mb]; m_val[mb][h] = 1; m_pend[mb][h] = 1; m_iss[mb][h] = 0;
      m_head[mb] = (h + 1) % ND;
      touch(mb);
    end
    if (e_alloc) begin
      int acc = addr & MASK;
      for (int i = 0; i < NB; i++) if (m_age[i] == NB - 1) vb = i;
      for (int s = 0; s < ND; s++) begin
        acc = (acc + stride) & MASK;
        m_tag[vb][s] = acc; m_val[vb][s] = 1; m_pend[vb][s] = 1; m_iss[vb][s] = 0;
      end
      m_last[vb] = acc; m_head[vb] = 0; m_str[vb] = stride;
      touch(vb);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_head[b] = 0; m_last[b] = 0; m_str[b] = 0; m_age[b] = NB - 1 - b;
      for (int s = 0; s < ND; s++) begin
        m_tag[b][s] = 0; m_val[b][s] = 0; m_pend[b][s] = 0; m_iss[b][s] = 0;
      end
    end
    repeat (3) @(posedge clk);
    #2;
    cur_req = "R10";
    chk(pf_req_valid == 0 && sup_valid == 0 && lk_stall == 0, "reset outputs",
        {pf_req_valid, sup_valid, lk_stall}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    cur_req = "R1";   // cache hits leave everything untouched
    for (int i = 0; i < 4; i++) step(1, 1, 'h100 + i, 1);
    cur_req = "R4";   // full miss allocates buffer 0
    step(1, 0, 'h100, 1);
    cur_req = "R5";   // four requests, one per cycle
    idle(5);
    cur_req = "R3";   // head still pending
    step(1, 0, 'h101, 1);
    cur_req = "R7";   // fill with a wrong address is ignored
    inj_v = 1; inj_b = 0; inj_s = 0; inj_a = 'h999;
    step(0, 0, 0, 0);
    step(1, 0, 'h101, 1);
    inj_v = 1; inj_b = 0; inj_s = 1; inj_a = 'h101;   // right address, wrong slot
    step(0, 0, 0, 0);
    step(1, 0, 'h101, 1);
    mem_on = 1;
    idle(12);
    cur_req = "R2";
    step(1, 0, 'h101, 1);
    step(1, 0, 'h102, 1);
    cur_req = "R6";
    for (int i = 3; i < 10; i++) begin step(1, 0, 'h100 + i, 1); idle(4); end
    cur_req = "R9";   // wrap forward and backward
    step(1, 0, 'hFFFE, 3);
    step(1, 0, 'h0002, -2);
    idle(14);
    step(1, 0, 'h0001, 3);
    step(1, 0, 'h0000, -2);
    idle(6);
    step(1, 0, 'hFFFE, -2);
    cur_req = "R8";   // fill all buffers then force replacements
    step(1, 0, 'h500, 4);
    idle(3);
    step(1, 0, 'h800, 1);
    idle(3);
    step(1, 0, 'h900, 2);
    idle(10);
    step(1, 0, 'h504, 4);
    step(1, 0, 'hA00, 1);
    idle(10);
    cur_req = "R2";   // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom % 10);
      int b = int'($urandom % NB);
      int strs[4] = '{1, 2, -1, 3};
      if (r < 5) step(1, ($urandom % 4) == 0, m_tag[b][m_head[b]], strs[b]);
      else if (r < 7) step(1, 0, int'($urandom % 'h10000), strs[b]);
      else idle(1);
    end
    idle(20);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule